// File: doc/BRIEF.md
# Bidirectional GPIO Port with Pullups

This block controls one port of eight general-purpose pins. Software configures it through a small register interface. It takes an address, a write strobe, write data, and returns read data. Three registers sit behind that interface:

- **Output-level register.** On an output pin it sets the driven level. On an input pin it switches on the pin's pullup.
- **Direction register.** A 1 makes the pin an output; a 0 makes it an input.
- **Pin-sample register.** This register is read-only. It returns the levels seen on the pads, whatever direction each pin has.

The block drives the pad's output enable, output value and pullup enable for every pin. Bit n of each register belongs to pin n.

Two chip-wide controls act on every port:

- **Pullup disable.** This turns every pullup off.
- **Sleep.** This gates the incoming pad levels to 0 before they reach the synchronizer, so that floating inputs do not toggle internal logic. Sleep leaves outputs and pullups as they are.

Pad levels pass through a synchronizer of two flops before they appear in the pin-sample register. A read therefore returns the level the pad had two clocks earlier.

Top module: `gpio_port`

## Requirements
- R1: After reset the output-level and direction registers are 0. padOe, padOut and padPullEn are then all 0, and reads of addresses 0, 1 and 3 return 0.
- R2: A write with regWrEn high at address 0 loads the output-level register at the clock edge. A write at address 1 loads the direction register. Reading address 0 or 1 returns the register combinationally.
- R3: padOe equals the direction register. padOut equals the output-level register ANDed with the direction register, so input pins drive 0.
- R4: padPullEn for pin n is 1 exactly when direction bit n is 0, output-level bit n is 1 and pullDisable is 0.
- R5: Reading address 2 returns padIn as it was sampled at the clock edge two edges before the read, whatever the direction bits are.
- R6: While sleepReq is high at a sampling edge, the value entering the synchronizer is 0. A pin-sample read two edges later therefore returns 0. Sleep has no effect on padOe, padOut or padPullEn.
- R7: Writes to address 2 or 3 change no register. Reading address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 2 | Register address: 0 output level, 1 direction, 2 pin sample, 3 unused |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr |
| pullDisable | input | 1 | Chip-wide pullup disable |
| sleepReq | input | 1 | Chip-wide sleep; gates pad inputs to 0 |
| padIn | input | 8 | Pad levels |
| padOe | output | 8 | Per-pin output enable |
| padOut | output | 8 | Per-pin driven level |
| padPullEn | output | 8 | Per-pin pullup enable |

## Verification
The bench builds the block with its defaults: eight pins and a synchronizer of two stages. With these values an exact two-edge latency and every address decode are observable from the ports. The bench drives all four addresses, with and without writes, while the direction and level patterns mix inputs and outputs on one port. This shows that each pin's pullup depends only on its own two bits and on pullDisable. Sleep and pullDisable are toggled against changing pad levels, so the gating of the sample path is seen both as it enters and as it leaves. The bench also shows that sleep does not reach the outputs.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    SEL_LEVEL = 2'd0,
    SEL_DIR   = 2'd1,
    SEL_PIN   = 2'd2,
    SEL_NONE  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    wrLevel;
    logic    wrDir;
    regSel_e rdSel;
  } portStrobe_t;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output portStrobe_t       strobe
);

  regSel_e sel;

  always_comb begin
    case (regAddr)
      ADDR_W'(0): sel = SEL_LEVEL;
      ADDR_W'(1): sel = SEL_DIR;
      ADDR_W'(2): sel = SEL_PIN;
      default:    sel = SEL_NONE;
    endcase
  end

  always_comb begin
    strobe.rdSel   = sel;
    strobe.wrLevel = regWrEn && (sel == SEL_LEVEL);
    strobe.wrDir   = regWrEn && (sel == SEL_DIR);
  end

endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  portStrobe_t      strobe,
  input  logic [WIDTH-1:0] regWrData,
  input  logic             pullDisable,
  input  logic             sleepReq,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] regRdData,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padPullEn
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [WIDTH-1:0] levelReg;
  logic [WIDTH-1:0] dirReg;
  logic [WIDTH-1:0] gatedIn;
  logic [WIDTH-1:0] syncQ [SYNC_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelReg <= '0;
      dirReg   <= '0;
    end else begin
      if (strobe.wrLevel) levelReg <= regWrData;
      if (strobe.wrDir)   dirReg   <= regWrData;
    end
  end

  // Sleep gates the pads before the first flop so nothing toggles downstream.
  assign gatedIn = sleepReq ? '0 : padIn;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       syncQ[s] <= '0;
      else if (s == 0) syncQ[s] <= gatedIn;
      else             syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
    end
  end

  for (genvar p = 0; p < WIDTH; p++) begin : g_pin
    assign padOe[p]     = dirReg[p];
    assign padOut[p]    = dirReg[p] & levelReg[p];
    assign padPullEn[p] = ~dirReg[p] & levelReg[p] & ~pullDisable;
  end

  always_comb begin
    case (strobe.rdSel)
      SEL_LEVEL: regRdData = levelReg;
      SEL_DIR:   regRdData = dirReg;
      SEL_PIN:   regRdData = syncQ[LAST];
      default:   regRdData = '0;
    endcase
  end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [WIDTH-1:0]  regWrData,
  output logic [WIDTH-1:0]  regRdData,
  input  logic              pullDisable,
  input  logic              sleepReq,
  input  logic [WIDTH-1:0]  padIn,
  output logic [WIDTH-1:0]  padOe,
  output logic [WIDTH-1:0]  padOut,
  output logic [WIDTH-1:0]  padPullEn
);

  portStrobe_t strobe;

  gpio_port_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strobe  (strobe)
  );

  gpio_port_dp #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .regWrData   (regWrData),
    .pullDisable (pullDisable),
    .sleepReq    (sleepReq),
    .padIn       (padIn),
    .regRdData   (regRdData),
    .padOe       (padOe),
    .padOut      (padOut),
    .padPullEn   (padPullEn)
  );

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [WIDTH-1:0]  regWrData,
  input logic [WIDTH-1:0]  regRdData,
  input logic              pullDisable,
  input logic              sleepReq,
  input logic [WIDTH-1:0]  padOe,
  input logic [WIDTH-1:0]  padOut,
  input logic [WIDTH-1:0]  padPullEn
);

  logic wasInReset = 1'b0;
  always_ff @(posedge clk) wasInReset <= !rstN;

  always @(posedge clk) begin
    if (rstN && wasInReset)
      AST_RESET_IDLE: assert (padOe == '0 && padOut == '0 && padPullEn == '0); // R1
  end

  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(1)) |=> (padOe == $past(regWrData))); // R2

  AST_PULL_INPUT_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    ((padPullEn & padOe) == '0)); // R4

  AST_PULL_DISABLE: assert property (@(posedge clk) disable iff (!rstN)
    pullDisable |-> (padPullEn == '0)); // R4

  AST_SLEEP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(2) && $past(sleepReq, 2)) |-> (regRdData == '0)); // R6

  AST_PIN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(2)) |=> ($stable(padOe) && $stable(padOut))); // R7

endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .regAddr     (regAddr),
  .regWrEn     (regWrEn),
  .regWrData   (regWrData),
  .regRdData   (regRdData),
  .pullDisable (pullDisable),
  .sleepReq    (sleepReq),
  .padOe       (padOe),
  .padOut      (padOut),
  .padPullEn   (padPullEn)
);

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 50000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       pullDisable = 1'b0;
  logic       sleepReq = 1'b0;
  logic [7:0] padIn = '0;
  logic [7:0] padOe, padOut, padPullEn;

  int checks = 0;
  int errors = 0;

  // Behavioural reference state
  logic [7:0] mLevel = '0;
  logic [7:0] mDir = '0;
  logic [7:0] mHist[$] = '{8'h00, 8'h00};

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .pullDisable(pullDisable),
    .sleepReq(sleepReq), .padIn(padIn), .padOe(padOe), .padOut(padOut),
    .padPullEn(padPullEn)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mLevel = '0;
      mDir   = '0;
      mHist  = '{8'h00, 8'h00};
    end else begin
      if (regWrEn && regAddr == 2'd0) mLevel = regWrData;
      if (regWrEn && regAddr == 2'd1) mDir   = regWrData;
      mHist.push_back(sleepReq ? 8'h00 : padIn);
      void'(mHist.pop_front());
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      logic [7:0] expRd;
      string tag;
      case (regAddr)
        2'd0: begin expRd = mLevel;   tag = "R2"; end
        2'd1: begin expRd = mDir;     tag = "R2"; end
        2'd2: begin expRd = mHist[0]; tag = "R5"; end
        default: begin expRd = 8'h00; tag = "R7"; end
      endcase
      check("R3", "padOe", padOe, mDir);
      check("R3", "padOut", padOut, mLevel & mDir);
      check("R4", "padPullEn", padPullEn, ~mDir & mLevel & {8{~pullDisable}});
      check(tag, "regRdData", regRdData, expRd);
    end
  end

  task automatic drive(input logic [1:0] a, input logic we, input logic [7:0] wd,
                       input logic [7:0] pin, input logic pd, input logic slp);
    @(posedge clk);
    #(CLK_PERIOD/4);
    regAddr = a; regWrEn = we; regWrData = wd;
    padIn = pin; pullDisable = pd; sleepReq = slp;
  endtask

  task automatic probe(input logic [1:0] a);
    drive(a, 1'b0, 8'h00, padIn, pullDisable, sleepReq);
    @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    rstN = 1'b1;
    @(negedge clk); #1;
    check("R1", "padOe after reset", padOe, 8'h00);
    check("R1", "padPullEn after reset", padPullEn, 8'h00);
    check("R1", "padOut after reset", padOut, 8'h00);
    probe(2'd0);
    check("R1", "level readback after reset", regRdData, 8'h00);

    drive(2'd1, 1'b1, 8'h0F, 8'h3C, 1'b0, 1'b0);
    drive(2'd0, 1'b1, 8'hA5, 8'h3C, 1'b0, 1'b0);
    probe(2'd1);
    check("R2", "dir readback", regRdData, 8'h0F);
    check("R3", "padOut mixed", padOut, 8'h05);
    check("R4", "pullups on inputs", padPullEn, 8'hA0);
    probe(2'd2);
    check("R5", "pin sample", regRdData, 8'h3C);

    drive(2'd0, 1'b0, 8'h00, 8'h3C, 1'b1, 1'b0);
    @(negedge clk); #1;
    check("R4", "pullDisable", padPullEn, 8'h00);

    drive(2'd2, 1'b1, 8'h55, 8'hFF, 1'b0, 1'b1);
    drive(2'd3, 1'b1, 8'h66, 8'hFF, 1'b0, 1'b1);
    drive(2'd2, 1'b0, 8'h00, 8'hFF, 1'b0, 1'b1);
    @(negedge clk); #1;
    check("R6", "sleep gates sample", regRdData, 8'h00);
    check("R6", "sleep keeps padOut", padOut, 8'h05);
    check("R6", "sleep keeps pullups", padPullEn, 8'hA0);
    probe(2'd0);
    check("R7", "level after ignored writes", regRdData, 8'hA5);
    probe(2'd1);
    check("R7", "dir after ignored writes", regRdData, 8'h0F);
    probe(2'd3);
    check("R7", "addr 3 reads zero", regRdData, 8'h00);

    drive(2'd2, 1'b0, 8'h00, 8'hC3, 1'b0, 1'b0);
    drive(2'd2, 1'b0, 8'h00, 8'h18, 1'b0, 1'b0);
    @(negedge clk); #1;
    check("R5", "first sample after wake", regRdData, 8'h00);
    drive(2'd2, 1'b0, 8'h00, 8'h18, 1'b0, 1'b0);
    @(negedge clk); #1;
    check("R5", "sample after wake", regRdData, 8'hC3);

    for (int i = 0; i < 600; i++) begin
      drive(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 8'($urandom),
            8'($urandom), ($urandom_range(0, 3) == 0), ($urandom_range(0, 4) == 0));
    end

    drive(2'd0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0);
    @(negedge clk); #1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule